// File: doc/BRIEF.md
# Serial Bit-Rate Detector with Sync Confirmation

This block finds the bit rate of an asynchronous serial stream arriving on a single receive line. It then confirms the result by decoding the frames that follow. Detection is launched by a command. While it runs, the byte receiver is held off and its partial state is flushed. The block counts how many reference-clock cycles the first low pulse on the line lasts; ideally that pulse is the start bit of an all-ones byte. A count that is too short or too long is thrown away and the block waits for the next low pulse. An accepted count is placed in one of five rate bins, and the matching clock divisor is loaded.

Once a rate is chosen, an 8N1 receiver decodes the following bytes. The sync stage treats the byte whose start bit was just measured as an all-ones byte already received. It then gives the sender a small budget of further bytes to produce the sync pattern 0x55. A match declares lock. If the budget runs out, the block drops back into detection on its own. A forced-rate command skips detection and locks at once. Received bytes leave through a valid/ready stream. A byte is held stable until it is accepted. A byte that completes while the holding register is still full is lost. Launching detection empties the holding register.

Top module: `autobaud_rx`

## Requirements
- R1: After reset the block is idle and unlocked, `rate_o` is 0 (9600), `divisor_o` is 77, and `m_valid_o` is low.
- R2: A `start_i` pulse clears `locked_o`, disables the receiver and empties the output register. No byte is delivered while measuring.
- R3: The width of the first low pulse is counted in reference cycles. A count below 189 or above 1388 is rejected and measurement re-arms for the next low pulse. The counter saturates, so a very long pulse is rejected rather than wrapping.
- R4: An accepted count maps to `rate_o`, using the first bin that matches: below 250 gives code 4 (57600); below 357 gives code 3 (38400); below 500 gives code 2 (28800); below 833 gives code 1 (19200); otherwise code 0 (9600).
- R5: `divisor_o` follows `rate_o`: code 0→77, 1→38, 2→25, 3→19, 4→12. One bit lasts (divisor+1)×16 reference cycles.
- R6: The receiver takes 8N1 frames, LSB first, sampled at mid-bit. A frame whose stop bit is low is dropped silently.
- R7: After detection the sync stage accepts up to 2 received bytes. A 0x55 sets `locked_o`. Any other well-formed byte uses up one try. A dropped frame uses up none.
- R8: When the tries run out without 0x55, the failing byte is discarded, the receiver is disabled and detection relaunches with `locked_o` low.
- R9: `force_i` has priority over `start_i`, and `start_i` has priority over `stop_i`. `force_i` aborts detection, loads the rate for `force_rate_i` (codes 5..7 select 9600), and raises `locked_o` on the next cycle.
- R10: While locked, `rate_o` and `divisor_o` do not change, whatever bytes arrive, until a start or forced-rate command.
- R11: `stop_i` returns the block to idle: unlocked, receiver off, and no detection on later pulses.
- R12: Output stream: `m_data_o` stays stable while `m_valid_o` is high and `m_ready_i` is low. A byte completing while the register is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (12 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| start_i | input | 1 | Launch rate detection |
| stop_i | input | 1 | Abort and return to idle |
| force_i | input | 1 | Load `force_rate_i` and lock |
| force_rate_i | input | 3 | Rate code for a forced rate |
| rate_o | output | 3 | Current rate code (0..4) |
| divisor_o | output | 8 | Divisor for the current rate |
| locked_o | output | 1 | Rate confirmed |
| m_valid_o | output | 1 | Received byte available |
| m_ready_i | input | 1 | Consumer accepts the byte |
| m_data_o | output | 8 | Received byte |

## Verification
Commands take effect on the next clock edge, and the bench samples them one cycle after the pulse. A measured pulse passes through the two-flop synchroniser, the timer register and the state register. The new rate therefore appears about four cycles after the line rises. The bench does not look before a 200-cycle quiet gap has passed. A received byte reaches the output register a few cycles after the middle of its stop bit. Lock, rate and stream checks therefore wait out two idle bit times after each frame. The stream monitor compares at the falling edge, where valid and ready are both stable.

// File: rtl/abd_pkg.sv
package abd_pkg;

  typedef enum logic [2:0] {
    RATE_9600  = 3'd0,
    RATE_19200 = 3'd1,
    RATE_28800 = 3'd2,
    RATE_38400 = 3'd3,
    RATE_57600 = 3'd4
  } rate_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_MEASURE, ST_SYNC, ST_LOCKED
  } mode_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_START, PH_DATA, PH_STOP
  } rxph_e;

  function automatic int baud_of(rate_e r);
    case (r)
      RATE_19200: return 19200;
      RATE_28800: return 28800;
      RATE_38400: return 38400;
      RATE_57600: return 57600;
      default:    return 9600;
    endcase
  endfunction

  // rounded clk/(ovs*baud) minus one
  function automatic int div_of(rate_e r, int clk_hz, int ovs);
    int d;
    d = ovs * baud_of(r);
    return (clk_hz + d / 2) / d - 1;
  endfunction

  function automatic rate_e rate_from_code(logic [2:0] c);
    if (c <= 3'd4) return rate_e'(c);
    return RATE_9600;
  endfunction

endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rx_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], rx_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign rx_o   = chain[STAGES-1];
  assign fall_o = prev & ~chain[STAGES-1];
  assign rise_o = ~prev & chain[STAGES-1];
endmodule

// File: rtl/abd_pulse_timer.sv
module abd_pulse_timer
  import abd_pkg::*;
#(
  parameter int CLK_HZ = 12_000_000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  logic  fall_i,
  input  logic  rise_i,
  output logic  done_o,
  output logic  ok_o,
  output rate_e rate_o
);
  localparam int CMIN = (CLK_HZ * 10) / (57600 * 11);
  localparam int CMAX = (CLK_HZ * 10) / (9600 * 9);
  localparam int T57  = CLK_HZ / 48000;
  localparam int T38  = CLK_HZ / 33600;
  localparam int T28  = CLK_HZ / 24000;
  localparam int T19  = CLK_HZ / 14400;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] cnt;
  logic          active;

  function automatic rate_e classify(logic [CW-1:0] c);
    if (c < CW'(T57)) return RATE_57600;
    if (c < CW'(T38)) return RATE_38400;
    if (c < CW'(T28)) return RATE_28800;
    if (c < CW'(T19)) return RATE_19200;
    return RATE_9600;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      done_o <= 1'b0;
      ok_o   <= 1'b0;
      rate_o <= RATE_9600;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        active <= 1'b0;
      end else if (!active) begin
        if (fall_i) begin
          active <= 1'b1;
          cnt    <= CW'(1);
        end
      end else if (rise_i) begin
        active <= 1'b0;
        done_o <= 1'b1;
        ok_o   <= (cnt >= CW'(CMIN)) && (cnt <= CW'(CMAX));
        rate_o <= classify(cnt);
      end else if (cnt != SAT) begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/abd_uart_rx.sv
module abd_uart_rx
  import abd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rx_i,
  input  logic             fall_i,
  output logic             vld_o,
  output logic [7:0]       data_o
);
  localparam int BW = DIV_W + $clog2(OVS) + 1;

  rxph_e         ph;
  logic [BW-1:0] cnt;
  logic [BW-1:0] bitlen;
  logic [2:0]    nbit;
  logic [7:0]    sh;

  always_comb bitlen = (BW'(div_i) + BW'(1)) * BW'(OVS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      nbit  <= '0;
      sh    <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (!en_i) begin
        ph <= PH_IDLE;
      end else if (ph == PH_IDLE) begin
        if (fall_i) begin
          cnt <= (bitlen >> 1) - BW'(1);
          ph  <= PH_START;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - BW'(1);
      end else begin
        cnt <= bitlen - BW'(1);
        case (ph)
          PH_START: begin
            nbit <= '0;
            ph   <= rx_i ? PH_IDLE : PH_DATA;
          end
          PH_DATA: begin
            sh   <= {rx_i, sh[7:1]};
            nbit <= nbit + 3'd1;
            if (nbit == 3'd7) ph <= PH_STOP;
          end
          default: begin
            ph    <= PH_IDLE;
            vld_o <= rx_i;
          end
        endcase
      end
    end
  end

  assign data_o = sh;
endmodule

// File: rtl/autobaud_rx.sv
module autobaud_rx
  import abd_pkg::*;
#(
  parameter int         CLK_HZ      = 12_000_000,
  parameter int         OVS         = 16,
  parameter int         DIV_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         SYNC_TRIES  = 2,
  parameter logic [7:0] SYNC_BYTE   = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             force_i,
  input  logic [2:0]       force_rate_i,
  output logic [2:0]       rate_o,
  output logic [DIV_W-1:0] divisor_o,
  output logic             locked_o,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [7:0]       m_data_o
);
  localparam int TW = $clog2(SYNC_TRIES + 1);

  mode_e          st;
  rate_e          rate_q;
  logic [TW-1:0]  tries;
  logic           rx_s, fall, rise;
  logic           pt_done, pt_ok;
  rate_e          pt_rate;
  logic           rx_vld;
  logic [7:0]     rx_byte;
  logic           rx_en, measuring, relaunch, cmd, accept, flush;

  abd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
    .rx_o(rx_s), .fall_o(fall), .rise_o(rise)
  );

  abd_pulse_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(measuring),
    .fall_i(fall), .rise_i(rise),
    .done_o(pt_done), .ok_o(pt_ok), .rate_o(pt_rate)
  );

  abd_uart_rx #(.DIV_W(DIV_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(rx_en), .div_i(divisor_o),
    .rx_i(rx_s), .fall_i(fall), .vld_o(rx_vld), .data_o(rx_byte)
  );

  always_comb begin
    measuring = (st == ST_MEASURE);
    rx_en     = (st == ST_SYNC) || (st == ST_LOCKED);
    cmd       = force_i | start_i | stop_i;
    relaunch  = !cmd && (st == ST_SYNC) && rx_vld &&
                (rx_byte != SYNC_BYTE) && (tries == TW'(1));
    accept    = !cmd && rx_en && rx_vld && !relaunch;
    flush     = (start_i && !force_i) || relaunch;
    divisor_o = DIV_W'(div_of(rate_q, CLK_HZ, OVS));
  end

  assign rate_o   = rate_q;
  assign locked_o = (st == ST_LOCKED);

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      rate_q <= RATE_9600;
      tries  <= '0;
    end else if (force_i) begin
      st     <= ST_LOCKED;
      rate_q <= rate_from_code(force_rate_i);
    end else if (start_i) begin
      st <= ST_MEASURE;
    end else if (stop_i) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_MEASURE: if (pt_done && pt_ok) begin
          st     <= ST_SYNC;
          rate_q <= pt_rate;
          tries  <= TW'(SYNC_TRIES);
        end
        ST_SYNC: if (rx_vld) begin
          if (rx_byte == SYNC_BYTE) st <= ST_LOCKED;
          else if (relaunch)        st <= ST_MEASURE;
          else                      tries <= tries - TW'(1);
        end
        default: ;
      endcase
    end
  end

  // one-entry output holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid_o <= 1'b0;
      m_data_o  <= '0;
    end else if (flush) begin
      m_valid_o <= 1'b0;
    end else if (accept && (!m_valid_o || m_ready_i)) begin
      m_valid_o <= 1'b1;
      m_data_o  <= rx_byte;
    end else if (m_ready_i) begin
      m_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/autobaud_rx_chk.sv
module autobaud_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       stop_i,
  input logic       force_i,
  input logic       m_ready_i,
  input logic       locked_o,
  input logic [2:0] rate_o,
  input logic       m_valid_o,
  input logic [7:0] m_data_o,
  input logic       measuring,
  input logic       relaunch
);
  AST_NO_OUT_MEASURE: assert property (@(posedge clk) disable iff (!rst_n)
    measuring |-> !m_valid_o); // R2

  AST_START_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !force_i) |=> (!locked_o && measuring)); // R2

  AST_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    relaunch |=> (measuring && !locked_o && !m_valid_o)); // R8

  AST_FORCE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> locked_o); // R9

  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !force_i) |=> $stable(rate_o)); // R10

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i && !force_i) |=> (!locked_o && !measuring)); // R11

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i && !start_i && !relaunch) |=>
      (m_valid_o && $stable(m_data_o))); // R12
endmodule

bind autobaud_rx autobaud_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
  .force_i(force_i), .m_ready_i(m_ready_i), .locked_o(locked_o),
  .rate_o(rate_o), .m_valid_o(m_valid_o), .m_data_o(m_data_o),
  .measuring(measuring), .relaunch(relaunch)
);

// File: tb/sim_autobaud_rx.sv
module sim_autobaud_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       start = 1'b0, stop = 1'b0, force_cmd = 1'b0;
  logic [2:0] force_rate = 3'd0;
  logic [2:0] rate;
  logic [7:0] divisor;
  logic       locked, m_valid, m_ready = 1'b1;
  logic [7:0] m_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] expq[$];

  always #4 clk = ~clk;

  autobaud_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .start_i(start), .stop_i(stop),
    .force_i(force_cmd), .force_rate_i(force_rate), .rate_o(rate),
    .divisor_o(divisor), .locked_o(locked), .m_valid_o(m_valid),
    .m_ready_i(m_ready), .m_data_o(m_data)
  );

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int bl, input bit stop_ok);
    rx = 1'b0; tick(bl);
    for (int i = 0; i < 8; i++) begin rx = b[i]; tick(bl); end
    rx = stop_ok; tick(bl);
    rx = 1'b1; tick(2 * bl);
  endtask

  task automatic pulse(input int n);
    rx = 1'b0; tick(n);
    rx = 1'b1; tick(200);
  endtask

  task automatic do_start();
    start = 1'b1; tick(1); start = 1'b0; tick(4);
  endtask

  task automatic do_force(input logic [2:0] code, input bit with_start);
    force_rate = code; force_cmd = 1'b1; start = with_start;
    tick(1);
    force_cmd = 1'b0; start = 1'b0;
  endtask

  function automatic int div_exp(input int code);
    case (code)
      1: return 38; 2: return 25; 3: return 19; 4: return 12;
      default: return 77;
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      if (expq.size() == 0) chk(1'b0, "R12 unexpected byte", int'(m_data), -1);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(m_data == e, "R6 byte value", int'(m_data), int'(e));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bls[5];
    bls[0] = 1250; bls[1] = 625; bls[2] = 416; bls[3] = 312; bls[4] = 208;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    chk(!locked, "R1 locked", locked, 0);
    chk(rate == 3'd0, "R1 rate", rate, 0);
    chk(divisor == 8'd77, "R1 divisor", divisor, 77);
    chk(!m_valid, "R1 m_valid", m_valid, 0);

    // detection at each rate, fastest first
    for (int k = 4; k >= 0; k--) begin
      do_start();
      chk(!locked, "R2 unlocked after start", locked, 0);
      send_byte(8'hFF, bls[k], 1'b1);
      chk(!locked && !m_valid, "R2 no lock or byte yet", locked, 0);
      if (k == 3) begin
        expq.push_back(8'hFF);
        send_byte(8'hFF, bls[k], 1'b1);
      end
      expq.push_back(8'h55);
      send_byte(8'h55, bls[k], 1'b1);
      chk(locked, "R7 locked after sync", locked, 1);
      chk(rate == 3'(k), "R4 rate bin", rate, k);
      chk(divisor == 8'(div_exp(k)), "R5 divisor", divisor, div_exp(k));
    end

    // out-of-range pulses (rate currently 0)
    do_start();
    pulse(150);
    chk(rate == 3'd0 && !locked, "R3 short pulse rejected", rate, 0);
    pulse(185);
    chk(rate == 3'd0 && !locked, "R3 short pulse 185 rejected", rate, 0);
    do_force(3'd4, 1'b0);
    chk(locked, "R9 force locks", locked, 1);
    chk(rate == 3'd4 && divisor == 8'd12, "R9 forced rate", rate, 4);
    do_start();
    chk(!locked, "R2 start unlocks", locked, 0);
    pulse(1500);
    chk(rate == 3'd4 && !locked, "R3 long pulse rejected", rate, 4);
    pulse(5000);
    chk(rate == 3'd4 && !locked, "R3 saturating counter", rate, 4);

    // force with start at once, unknown code
    do_force(3'd6, 1'b1);
    chk(locked && rate == 3'd0, "R9 priority and default rate", rate, 0);
    chk(divisor == 8'd77, "R9 default divisor", divisor, 77);

    // locked rate holds against wrong bytes
    expq.push_back(8'h12);
    send_byte(8'h12, 1250, 1'b1);
    chk(locked && rate == 3'd0, "R10 rate held while locked", rate, 0);

    // failed sync relaunches
    do_start();
    send_byte(8'hFF, 208, 1'b1);
    expq.push_back(8'h12);
    send_byte(8'h12, 208, 1'b1);
    chk(!locked && rate == 3'd4, "R7 one try used", rate, 4);
    send_byte(8'h34, 208, 1'b1);
    chk(!locked && !m_valid, "R8 relaunch after budget", locked, 0);
    send_byte(8'hFF, 625, 1'b1);
    expq.push_back(8'h55);
    send_byte(8'h55, 625, 1'b1);
    chk(locked && rate == 3'd1, "R8 redetect after relaunch", rate, 1);

    // bad stop bit costs no try
    do_start();
    send_byte(8'hFF, 312, 1'b1);
    send_byte(8'h11, 312, 1'b0);
    expq.push_back(8'h22);
    send_byte(8'h22, 312, 1'b1);
    expq.push_back(8'h55);
    send_byte(8'h55, 312, 1'b1);
    chk(locked && rate == 3'd3, "R6 framing drop keeps tries", rate, 3);

    // back-pressure
    m_ready = 1'b0;
    send_byte(8'hA1, 312, 1'b1);
    send_byte(8'hB2, 312, 1'b1);
    chk(m_valid, "R12 byte held", m_valid, 1);
    chk(m_data == 8'hA1, "R12 held data", m_data, 8'hA1);
    expq.push_back(8'hA1);
    m_ready = 1'b1;
    tick(3);
    chk(!m_valid, "R12 overrun byte dropped", m_valid, 0);

    // stop returns to idle
    stop = 1'b1; tick(1); stop = 1'b0; tick(2);
    chk(!locked, "R11 stop unlocks", locked, 0);
    send_byte(8'h55, 312, 1'b1);
    pulse(625);
    chk(!locked && rate == 3'd3 && !m_valid, "R11 idle ignores line", rate, 3);

    chk(expq.size() == 0, "R6 all bytes delivered", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule